// File: doc/BRIEF.md
# Memory Region Hazard Scoreboard

This block lets a processor keep issuing loads and stores while block-copy style array operations run alongside it. Each array operation reads one source memory block and writes one destination block. Both blocks are aligned and their size is a power of two, given as a base address plus a log2 size. The scoreboard holds every operation still in flight. It compares each processor access, and each newly offered array operation, against those records. Any ordering conflict (read-after-write, write-after-read or write-after-write) holds the requester back until the conflicting entry retires. The result is that the memory effects match plain program order.

Several array operations may be in flight at once. A newly offered operation is accepted only when a free slot exists and it conflicts with no older entry. The block reports which slot it took. When the datapath finishes an operation it names that slot on the retire input. The slot is freed at once, because no state carries from one operation to the next.

Top module: `region_hazard_sb`

## Requirements
- R1: After reset no entry is in flight: `cpu_stall` is 0 for any access, `op_busy` is 0, and an offered operation is accepted into slot 0.
- R2: Two blocks overlap exactly when their base addresses agree in every bit above the larger of the two log2 sizes. A processor access is a block of log2 size 0. Adjacent blocks, and blocks in disjoint halves of a larger region, do not overlap.
- R3: A processor load (`cpu_we`=0) stalls while it overlaps the destination block of an in-flight entry. A load that overlaps only source blocks does not stall.
- R4: A processor store (`cpu_we`=1) stalls while it overlaps the source or the destination block of any in-flight entry.
- R5: An offered operation whose source overlaps the destination of an in-flight entry gives `op_stall`=1 and `op_accept`=0.
- R6: An offered operation whose destination overlaps the source or destination of an in-flight entry gives `op_stall`=1 and `op_accept`=0.
- R7: A conflict-free operation offered while a slot is free is accepted in that cycle. It takes the lowest-numbered free slot, and `op_id` shows that slot.
- R8: While all four slots are in flight, `op_busy` is 1 and no operation is accepted.
- R9: A retire request for slot `ret_id` frees it at the next clock edge. From then on the stalls that entry caused are gone, and the slot can be allocated again.
- R10: Two operations whose sources overlap, with no other overlap, do not conflict. The second is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access present this cycle |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | AW | Processor access address |
| cpu_stall | output | 1 | Hold the processor access |
| op_valid | input | 1 | Array operation offered |
| op_src | input | AW | Source block base address |
| op_src_lg | input | LW | Source block log2 size |
| op_dst | input | AW | Destination block base address |
| op_dst_lg | input | LW | Destination block log2 size |
| op_accept | output | 1 | Operation taken into a slot at this edge |
| op_stall | output | 1 | Offered operation conflicts with an in-flight entry |
| op_busy | output | 1 | All slots in flight |
| op_id | output | IW | Slot given to the offered operation |
| ret_valid | input | 1 | Retire request |
| ret_id | input | IW | Slot being retired |

## Verification
The hardest state to reach is the one where each conflict is blamed on the right field of the right entry. Two entries must be in flight, with blocks of different sizes, so that one probe address touches only a source block or only a destination block. The bench loads such a pair and then walks a table of loads, stores and offered operations. Each offered operation is driven only between clock edges, so it never allocates a slot. A later sequence fills every slot, frees one in the middle and checks that this slot is the one reused.

// File: rtl/region_hazard_sb.sv
module region_hazard_sb #(
  parameter int AW   = 32,
  parameter int NENT = 4,
  localparam int LW  = $clog2(AW + 1),
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_stall,
  input  logic          op_valid,
  input  logic [AW-1:0] op_src,
  input  logic [LW-1:0] op_src_lg,
  input  logic [AW-1:0] op_dst,
  input  logic [LW-1:0] op_dst_lg,
  output logic          op_accept,
  output logic          op_stall,
  output logic          op_busy,
  output logic [IW-1:0] op_id,
  input  logic          ret_valid,
  input  logic [IW-1:0] ret_id
);

  logic [NENT-1:0] vld;
  logic [AW-1:0]   e_src [NENT];
  logic [AW-1:0]   e_dst [NENT];
  logic [LW-1:0]   e_slg [NENT];
  logic [LW-1:0]   e_dlg [NENT];
  logic [NENT-1:0] op_hit, cpu_hit;
  logic [IW-1:0]   free_id;

  function automatic logic ovl(input logic [AW-1:0] a, input logic [LW-1:0] la,
                               input logic [AW-1:0] b, input logic [LW-1:0] lb);
    logic [LW-1:0] m;
    m = (la > lb) ? la : lb;
    return (a >> m) == (b >> m);
  endfunction

  for (genvar gi = 0; gi < NENT; gi++) begin : g_ent
    assign op_hit[gi] = vld[gi] &&
      (ovl(op_src, op_src_lg, e_dst[gi], e_dlg[gi]) ||
       ovl(op_dst, op_dst_lg, e_src[gi], e_slg[gi]) ||
       ovl(op_dst, op_dst_lg, e_dst[gi], e_dlg[gi]));
    assign cpu_hit[gi] = vld[gi] &&
      (ovl(cpu_addr, '0, e_dst[gi], e_dlg[gi]) ||
       (cpu_we && ovl(cpu_addr, '0, e_src[gi], e_slg[gi])));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[gi] <= 1'b0;
      end else if (op_accept && free_id == IW'(gi)) begin
        vld[gi]   <= 1'b1;
        e_src[gi] <= op_src;
        e_slg[gi] <= op_src_lg;
        e_dst[gi] <= op_dst;
        e_dlg[gi] <= op_dst_lg;
      end else if (ret_valid && ret_id == IW'(gi)) begin
        vld[gi] <= 1'b0;
      end
    end
  end

  always_comb begin
    free_id = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (!vld[i]) free_id = IW'(i);
  end

  assign op_busy   = &vld;
  assign op_stall  = |op_hit;
  assign op_accept = op_valid && !op_busy && !op_stall;
  assign op_id     = free_id;
  assign cpu_stall = cpu_valid && |cpu_hit;

  p_idle_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == '0) |-> !cpu_stall);

  p_accept_free_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |-> !vld[op_id]);

  p_accept_allocates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |=> vld[$past(op_id)]);

  p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !ret_valid) |=> op_busy);

  p_conflict_no_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stall && !ret_valid) |=> $stable(vld));

  p_retire_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !(op_accept && op_id == ret_id)) |=> !vld[$past(ret_id)]);

endmodule

// File: tb/tb_region_hazard_sb.sv
`timescale 1ns/1ps
module tb_region_hazard_sb;
  localparam int AW = 32;
  localparam int LW = 6;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_stall;
  logic op_valid = 0;
  logic [AW-1:0] op_src = '0, op_dst = '0;
  logic [LW-1:0] op_src_lg = '0, op_dst_lg = '0;
  logic op_accept, op_stall, op_busy;
  logic [IW-1:0] op_id;
  logic ret_valid = 0;
  logic [IW-1:0] ret_id = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  region_hazard_sb dut (.*);

  // {we, addr, expected stall}; entries: E0 src 0x1000/lg8 dst 0x2000/lg8, E1 src 0x4000/lg4 dst 0x8000/lg12
  localparam logic [33:0] CPU_V [9] = '{
    {1'b0, 32'h0000_1010, 1'b0},
    {1'b1, 32'h0000_1010, 1'b1},
    {1'b0, 32'h0000_20FF, 1'b1},
    {1'b0, 32'h0000_2100, 1'b0},
    {1'b1, 32'h0000_400F, 1'b1},
    {1'b1, 32'h0000_4010, 1'b0},
    {1'b0, 32'h0000_8ABC, 1'b1},
    {1'b1, 32'h0000_9000, 1'b0},
    {1'b0, 32'h0000_0000, 1'b0}
  };
  // {src, src_lg, dst, dst_lg, expected accept}
  localparam logic [76:0] OP_V [6] = '{
    {32'h0000_2080, 6'd4, 32'h0000_3000, 6'd4, 1'b0},
    {32'h0000_3000, 6'd4, 32'h0000_1000, 6'd2, 1'b0},
    {32'h0000_3000, 6'd4, 32'h0000_8800, 6'd4, 1'b0},
    {32'h0000_3000, 6'd4, 32'h0000_0000, 6'd16, 1'b0},
    {32'h0000_1000, 6'd8, 32'h0000_3000, 6'd8, 1'b1},
    {32'h0000_3000, 6'd4, 32'h0000_2100, 6'd8, 1'b1}
  };
  localparam string OP_TAG [6] = '{"R5", "R6", "R6", "R2", "R10", "R2"};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cpu_probe(input logic we, input logic [AW-1:0] a, input logic exp, input string tag);
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = a;
    #1 check(cpu_stall == exp, tag, cpu_stall, exp);
    cpu_valid = 0;
  endtask

  task automatic op_probe(input logic [AW-1:0] s, input logic [LW-1:0] sl,
                          input logic [AW-1:0] d, input logic [LW-1:0] dl,
                          input logic exp, input string tag);
    @(negedge clk);
    op_valid = 1; op_src = s; op_src_lg = sl; op_dst = d; op_dst_lg = dl;
    #1 check(op_accept == exp, tag, op_accept, exp);
    op_valid = 0;
  endtask

  task automatic issue(input logic [AW-1:0] s, input logic [LW-1:0] sl,
                       input logic [AW-1:0] d, input logic [LW-1:0] dl,
                       input logic [IW-1:0] exp_id, input string tag);
    @(negedge clk);
    op_valid = 1; op_src = s; op_src_lg = sl; op_dst = d; op_dst_lg = dl;
    #1 check(op_accept == 1'b1, tag, op_accept, 1);
    check(op_id == exp_id, tag, op_id, exp_id);
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic retire(input logic [IW-1:0] id);
    @(negedge clk);
    ret_valid = 1; ret_id = id;
    @(negedge clk);
    ret_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    cpu_probe(1'b1, 32'h0000_1000, 1'b0, "R1 idle store");
    #0 check(op_busy == 1'b0, "R1 busy", op_busy, 0);
    issue(32'h0000_1000, 6'd8, 32'h0000_2000, 6'd8, 2'd0, "R1 first slot");
    issue(32'h0000_4000, 6'd4, 32'h0000_8000, 6'd12, 2'd1, "R7 second slot");

    for (int i = 0; i < 9; i++)
      cpu_probe(CPU_V[i][33], CPU_V[i][32:1], CPU_V[i][0], CPU_V[i][33] ? "R4 store" : "R3 load");
    for (int i = 0; i < 6; i++)
      op_probe(OP_V[i][76:45], OP_V[i][44:39], OP_V[i][38:7], OP_V[i][6:1], OP_V[i][0], OP_TAG[i]);

    issue(32'h0001_0000, 6'd4, 32'h0001_1000, 6'd4, 2'd2, "R7 third slot");
    issue(32'h0001_2000, 6'd4, 32'h0001_3000, 6'd4, 2'd3, "R7 fourth slot");
    @(negedge clk);
    #1 check(op_busy == 1'b1, "R8 busy when full", op_busy, 1);
    op_probe(32'h0001_4000, 6'd4, 32'h0001_5000, 6'd4, 1'b0, "R8 refused when full");

    retire(2'd1);
    #1 check(op_busy == 1'b0, "R9 busy clears", op_busy, 0);
    cpu_probe(1'b0, 32'h0000_8000, 1'b0, "R9 load after retire");
    issue(32'h0001_4000, 6'd4, 32'h0001_5000, 6'd4, 2'd1, "R9 freed slot reused");

    cpu_probe(1'b0, 32'h0000_2000, 1'b1, "R3 before retire");
    retire(2'd0);
    cpu_probe(1'b0, 32'h0000_2000, 1'b0, "R9 load clears");
    cpu_probe(1'b1, 32'h0000_1000, 1'b0, "R9 store clears");
    op_probe(32'h0000_2000, 6'd4, 32'h0000_6000, 6'd4, 1'b1, "R9 op after retire");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule